// File: doc/BRIEF.md
# Debug Hart Run-Control Unit

This unit holds the control and status state a debugger uses to stop, restart and reset a small group of processor harts. The debugger reaches it through a 32-bit register read/write port. A select field in the control register picks one hart. The unit turns the control fields into per-hart halt-request, resume-request and reset lines. It also takes back per-hart notifications when a hart has halted or is resuming.

The status register is computed live for the selected hart. Every condition is reported as an all/any pair. The pair is nonexistent when the select value is at or above the hart count. Otherwise it is halted or running, according to that hart's halted bit. A resume-acknowledge pair follows the hart's acknowledge bit. The unavailable pair always reads 0. Authenticated and implicit-break always read 1, and the version field always reads 2.

Restarting a hart is a handshake. A resume write raises a per-hart resume flag and clears that hart's acknowledge bit. When the hart reports that it is resuming, the flag drops, the hart is marked running and its acknowledge bit is set. The harts appear at the boundary as simple pulse inputs.

Top module: `dbg_run_ctrl`

## Requirements
- R1: After reset, all halt, resume and reset outputs are 0. The control register reads 0, and status reads running with the constant fields for hart 0.
- R2: The halt (bit 4), resume (bit 3), hart-reset (bit 2), system-reset (bit 1) and hart-select (bits 11:8) fields of the control register (address 0x08) are taken from a write only when that write has the active bit (bit 0) set. A write with bit 0 clear keeps those fields, clears the active bit and gates the halt and reset outputs off.
- R3: A control write that takes the active bit from 0 to 1 first clears every control field and every hart's resume flag and acknowledge bit, and only then applies the written fields.
- R4: halt_req_o is a level on the selected existing hart only. It stays set until a control write clears the halt bit, and at most one bit is set.
- R5: An active control write with the resume bit set raises resume_req_o for the selected existing hart and clears its acknowledge bit. A resuming pulse from that hart drops the flag, marks the hart running and sets its acknowledge bit. A resume aimed at a nonexistent hart raises nothing.
- R6: A halted pulse from a hart marks it halted. The status register (address 0x09) then reports all-halted in bit 0 and any-halted in bit 1.
- R7: Status bits 2/3 report all/any-running. Bits 6/7 report all/any-nonexistent, and are set when the select value is at or above the hart count. Bits 8/9 report all/any resume-acknowledge. Bits 4/5 (unavailable) are always 0.
- R8: Status bit 10 (authenticated) and bit 11 (implicit break) always read 1, and bits 15:12 (version) always read 2.
- R9: An active system reset drives every hart_reset_o bit. An active hart reset drives only the bit of the selected existing hart.
- R10: Every request gets a response exactly one cycle later. A read of any address other than 0x08 or 0x09 returns 0 with rsp_err_o set for that one cycle. Writes to such addresses, and writes to the status address, change nothing.
- R11: If a halted pulse and a resuming pulse reach the same hart in the same cycle, the hart ends halted with its resume flag cleared and its acknowledge bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Register address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response, one cycle after the request |
| rsp_err_o | output | 1 | Read of an unmapped address |
| rsp_rdata_o | output | DATA_W | Read data |
| hart_halted_i | input | NUM_HARTS | Per-hart pulse: hart has halted |
| hart_resuming_i | input | NUM_HARTS | Per-hart pulse: hart is resuming |
| halt_req_o | output | NUM_HARTS | Per-hart halt request level |
| resume_req_o | output | NUM_HARTS | Per-hart pending resume flag |
| hart_reset_o | output | NUM_HARTS | Per-hart reset request |

## Verification
On every cycle, the assertions check these properties:
- the one-cycle response timing;
- the error flag, which must appear exactly for unmapped reads;
- the constant and unavailable status fields;
- the exclusive halt-request line;
- the shape of the reset vector (none, one, or all);
- the dropping of a resume flag after a resuming pulse;
- that nonexistent never appears together with halted or running.

Only the bench scenarios can show:
- the capture rule that depends on the active bit;
- the activation clear of resume state;
- the full resume handshake, including the acknowledge pair;
- the priority when a halted and a resuming pulse coincide;
- that stray writes leave the control register unchanged.

// File: rtl/dbg_rc_pkg.sv
package dbg_rc_pkg;

    // control register bit positions
    localparam int unsigned CB_ACTIVE  = 0;
    localparam int unsigned CB_SYSRST  = 1;
    localparam int unsigned CB_HARTRST = 2;
    localparam int unsigned CB_RESUME  = 3;
    localparam int unsigned CB_HALT    = 4;
    localparam int unsigned CB_SEL_LSB = 8;

    // status register bit positions
    localparam int unsigned SB_ALL_HALT    = 0;
    localparam int unsigned SB_ANY_HALT    = 1;
    localparam int unsigned SB_ALL_RUN     = 2;
    localparam int unsigned SB_ANY_RUN     = 3;
    localparam int unsigned SB_ALL_UNAVAIL = 4;
    localparam int unsigned SB_ANY_UNAVAIL = 5;
    localparam int unsigned SB_ALL_NONEX   = 6;
    localparam int unsigned SB_ANY_NONEX   = 7;
    localparam int unsigned SB_ALL_RESACK  = 8;
    localparam int unsigned SB_ANY_RESACK  = 9;
    localparam int unsigned SB_AUTH        = 10;
    localparam int unsigned SB_IMPL_BREAK  = 11;
    localparam int unsigned SB_VER_LSB     = 12;
    localparam logic [3:0]  STATUS_VERSION = 4'd2;

    // packed so that bit n of the struct matches control bit n
    typedef struct packed {
        logic halt;
        logic resume;
        logic hart_rst;
        logic sys_rst;
        logic active;
    } ctrl_flags_t;

endpackage

// File: rtl/dbg_rc_regif.sv
module dbg_rc_regif
    import dbg_rc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned CTRL_ADDR = 8,
    parameter int unsigned STAT_ADDR = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] status_word_i,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output ctrl_flags_t       flags_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              activate_o,
    output logic              resume_set_o,
    output logic [SEL_W-1:0]  cmd_sel_o
);

    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_ADDR);
    localparam int unsigned       FLAGS_W = $bits(ctrl_flags_t);

    typedef struct packed {
        ctrl_flags_t       flags;
        logic [SEL_W-1:0]  sel;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rdata;
    } regif_state_t;

    regif_state_t s_d, s_q;
    logic         wr_ctrl_d;
    logic         rd_d;
    ctrl_flags_t  wr_flags_d;
    logic         activate_d;

    always_comb begin
        wr_ctrl_d  = req_valid_i && req_write_i && (req_addr_i == CTRL_A);
        rd_d       = req_valid_i && !req_write_i;
        wr_flags_d = ctrl_flags_t'(req_wdata_i[FLAGS_W-1:0]);
        activate_d = wr_ctrl_d && !s_q.flags.active && wr_flags_d.active;

        s_d           = s_q;
        s_d.rsp_valid = req_valid_i;
        s_d.rsp_err   = 1'b0;
        s_d.rdata     = '0;

        if (rd_d) begin
            if (req_addr_i == CTRL_A) begin
                s_d.rdata[FLAGS_W-1:0]           = s_q.flags;
                s_d.rdata[CB_SEL_LSB +: SEL_W]   = s_q.sel;
            end else if (req_addr_i == STAT_A) begin
                s_d.rdata = status_word_i;
            end else begin
                s_d.rsp_err = 1'b1;
            end
        end

        if (wr_ctrl_d) begin
            if (activate_d) begin
                s_d.flags = '0;
                s_d.sel   = '0;
            end
            if (wr_flags_d.active) begin
                s_d.flags = wr_flags_d;
                s_d.sel   = req_wdata_i[CB_SEL_LSB +: SEL_W];
            end else begin
                s_d.flags.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid_o  = s_q.rsp_valid;
    assign rsp_err_o    = s_q.rsp_err;
    assign rsp_rdata_o  = s_q.rdata;
    assign flags_o      = s_q.flags;
    assign sel_o        = s_q.sel;
    assign activate_o   = activate_d;
    assign resume_set_o = wr_ctrl_d && wr_flags_d.active && wr_flags_d.resume;
    assign cmd_sel_o    = req_wdata_i[CB_SEL_LSB +: SEL_W];

endmodule

// File: rtl/dbg_rc_hart_state.sv
module dbg_rc_hart_state #(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned SEL_W     = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 activate_i,
    input  logic                 resume_set_i,
    input  logic [SEL_W-1:0]     cmd_sel_i,
    input  logic [NUM_HARTS-1:0] halted_i,
    input  logic [NUM_HARTS-1:0] resuming_i,
    output logic [NUM_HARTS-1:0] halted_o,
    output logic [NUM_HARTS-1:0] resflag_o,
    output logic [NUM_HARTS-1:0] resack_o
);

    typedef struct packed {
        logic [NUM_HARTS-1:0] halted;
        logic [NUM_HARTS-1:0] resflag;
        logic [NUM_HARTS-1:0] resack;
    } hart_state_t;

    hart_state_t h_d, h_q;

    // order of precedence, lowest first: resuming, halted, activation, resume write
    always_comb begin
        h_d = h_q;
        for (int i = 0; i < NUM_HARTS; i++) begin
            if (resuming_i[i]) begin
                h_d.resflag[i] = 1'b0;
                h_d.halted[i]  = 1'b0;
                h_d.resack[i]  = 1'b1;
            end
            if (halted_i[i]) begin
                h_d.halted[i] = 1'b1;
            end
            if (activate_i) begin
                h_d.resflag[i] = 1'b0;
                h_d.resack[i]  = 1'b0;
            end
            if (resume_set_i && (cmd_sel_i == SEL_W'(i))) begin
                h_d.resflag[i] = 1'b1;
                h_d.resack[i]  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign halted_o  = h_q.halted;
    assign resflag_o = h_q.resflag;
    assign resack_o  = h_q.resack;

endmodule

// File: rtl/dbg_rc_status.sv
module dbg_rc_status
    import dbg_rc_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned DATA_W    = 32
) (
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [NUM_HARTS-1:0] halted_i,
    input  logic [NUM_HARTS-1:0] resack_i,
    output logic [DATA_W-1:0]    status_o
);

    logic exists_d;
    logic halted_d;
    logic resack_d;

    always_comb begin
        exists_d = 1'b0;
        halted_d = 1'b0;
        resack_d = 1'b0;
        for (int i = 0; i < NUM_HARTS; i++) begin
            if (sel_i == SEL_W'(i)) begin
                exists_d = 1'b1;
                halted_d = halted_i[i];
                resack_d = resack_i[i];
            end
        end

        status_o                          = '0;
        status_o[SB_ALL_HALT]             = exists_d && halted_d;
        status_o[SB_ANY_HALT]             = exists_d && halted_d;
        status_o[SB_ALL_RUN]              = exists_d && !halted_d;
        status_o[SB_ANY_RUN]              = exists_d && !halted_d;
        status_o[SB_ALL_UNAVAIL]          = 1'b0;
        status_o[SB_ANY_UNAVAIL]          = 1'b0;
        status_o[SB_ALL_NONEX]            = !exists_d;
        status_o[SB_ANY_NONEX]            = !exists_d;
        status_o[SB_ALL_RESACK]           = exists_d && resack_d;
        status_o[SB_ANY_RESACK]           = exists_d && resack_d;
        status_o[SB_AUTH]                 = 1'b1;
        status_o[SB_IMPL_BREAK]           = 1'b1;
        status_o[SB_VER_LSB +: 4]         = STATUS_VERSION;
    end

endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
    import dbg_rc_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CTRL_ADDR = 8,
    parameter int unsigned STAT_ADDR = 9
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [DATA_W-1:0]    req_wdata_i,
    output logic                 rsp_valid_o,
    output logic                 rsp_err_o,
    output logic [DATA_W-1:0]    rsp_rdata_o,
    input  logic [NUM_HARTS-1:0] hart_halted_i,
    input  logic [NUM_HARTS-1:0] hart_resuming_i,
    output logic [NUM_HARTS-1:0] halt_req_o,
    output logic [NUM_HARTS-1:0] resume_req_o,
    output logic [NUM_HARTS-1:0] hart_reset_o
);

    ctrl_flags_t          flags;
    logic [SEL_W-1:0]     sel;
    logic                 activate;
    logic                 resume_set;
    logic [SEL_W-1:0]     cmd_sel;
    logic [DATA_W-1:0]    status_word;
    logic [NUM_HARTS-1:0] halted;
    logic [NUM_HARTS-1:0] resflag;
    logic [NUM_HARTS-1:0] resack;

    dbg_rc_regif #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W),
        .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) i_regif (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_valid_i  (req_valid_i),
        .req_write_i  (req_write_i),
        .req_addr_i   (req_addr_i),
        .req_wdata_i  (req_wdata_i),
        .status_word_i(status_word),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_err_o    (rsp_err_o),
        .rsp_rdata_o  (rsp_rdata_o),
        .flags_o      (flags),
        .sel_o        (sel),
        .activate_o   (activate),
        .resume_set_o (resume_set),
        .cmd_sel_o    (cmd_sel)
    );

    dbg_rc_hart_state #(
        .NUM_HARTS(NUM_HARTS),
        .SEL_W    (SEL_W)
    ) i_hart_state (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .activate_i  (activate),
        .resume_set_i(resume_set),
        .cmd_sel_i   (cmd_sel),
        .halted_i    (hart_halted_i),
        .resuming_i  (hart_resuming_i),
        .halted_o    (halted),
        .resflag_o   (resflag),
        .resack_o    (resack)
    );

    dbg_rc_status #(
        .NUM_HARTS(NUM_HARTS),
        .SEL_W    (SEL_W),
        .DATA_W   (DATA_W)
    ) i_status (
        .sel_i   (sel),
        .halted_i(halted),
        .resack_i(resack),
        .status_o(status_word)
    );

    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
        logic sel_hit;
        assign sel_hit         = (sel == SEL_W'(g));
        assign halt_req_o[g]   = flags.active && flags.halt && sel_hit;
        assign hart_reset_o[g] = flags.active && (flags.sys_rst || (flags.hart_rst && sel_hit));
    end

    assign resume_req_o = resflag;

endmodule

// File: rtl/dbg_run_ctrl_chk.sv
module dbg_run_ctrl_chk
    import dbg_rc_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CTRL_ADDR = 8,
    parameter int unsigned STAT_ADDR = 9
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 req_valid_i,
    input logic                 req_write_i,
    input logic [ADDR_W-1:0]    req_addr_i,
    input logic                 rsp_valid_o,
    input logic                 rsp_err_o,
    input logic [DATA_W-1:0]    rsp_rdata_o,
    input logic [NUM_HARTS-1:0] hart_resuming_i,
    input logic [NUM_HARTS-1:0] halt_req_o,
    input logic [NUM_HARTS-1:0] resume_req_o,
    input logic [NUM_HARTS-1:0] hart_reset_o
);

    logic mapped;
    logic stat_rd;
    assign mapped  = (req_addr_i == ADDR_W'(CTRL_ADDR)) || (req_addr_i == ADDR_W'(STAT_ADDR));
    assign stat_rd = req_valid_i && !req_write_i && (req_addr_i == ADDR_W'(STAT_ADDR));

    AST_HALT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(halt_req_o)); // R4

    AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o); // R10

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o); // R10

    AST_UNMAPPED_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_write_i && !mapped) |=> (rsp_err_o && rsp_rdata_o == '0)); // R10

    AST_ERR_ONLY_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_valid_i || req_write_i || mapped) |=> !rsp_err_o); // R10

    AST_STATUS_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_rd |=> (rsp_rdata_o[SB_AUTH] && rsp_rdata_o[SB_IMPL_BREAK]
                     && rsp_rdata_o[SB_VER_LSB +: 4] == STATUS_VERSION)); // R8

    AST_UNAVAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_rd |=> (!rsp_rdata_o[SB_ALL_UNAVAIL] && !rsp_rdata_o[SB_ANY_UNAVAIL])); // R7

    AST_NONEX_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_rd |=> !(rsp_rdata_o[SB_ALL_NONEX]
                      && (rsp_rdata_o[SB_ALL_HALT] || rsp_rdata_o[SB_ALL_RUN]))); // R7

    AST_RESET_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(hart_reset_o) <= 1) || (&hart_reset_o)); // R9

    AST_RESUME_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hart_resuming_i != '0 && !(req_valid_i && req_write_i))
        |=> ((resume_req_o & $past(hart_resuming_i)) == '0)); // R5

endmodule

bind dbg_run_ctrl dbg_run_ctrl_chk #(
    .NUM_HARTS(NUM_HARTS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR)
) i_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_write_i    (req_write_i),
    .req_addr_i     (req_addr_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_err_o      (rsp_err_o),
    .rsp_rdata_o    (rsp_rdata_o),
    .hart_resuming_i(hart_resuming_i),
    .halt_req_o     (halt_req_o),
    .resume_req_o   (resume_req_o),
    .hart_reset_o   (hart_reset_o)
);

// File: tb/test_dbg_run_ctrl.sv
module test_dbg_run_ctrl;

    localparam int unsigned NH     = 4;
    localparam int unsigned AW     = 7;
    localparam int unsigned DW     = 32;
    localparam logic [AW-1:0] A_CTRL = 7'h08;
    localparam logic [AW-1:0] A_STAT = 7'h09;
    localparam logic [AW-1:0] A_BAD  = 7'h3F;
    localparam int unsigned NVEC   = 6;

    // control value, expected halt_req_o, expected status word
    localparam logic [31:0] V_CTRL [NVEC] = '{32'h011, 32'h211, 32'h301, 32'h511, 32'hF11, 32'h110};
    localparam logic [3:0]  V_HALT [NVEC] = '{4'b0001, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0000};
    localparam logic [31:0] V_STAT [NVEC] = '{32'h2C0C, 32'h2C0C, 32'h2C0C, 32'h2CC0, 32'h2CC0, 32'h2CC0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [NH-1:0] halted_in = '0;
    logic [NH-1:0] resuming_in = '0;
    logic [NH-1:0] halt_req;
    logic [NH-1:0] resume_req;
    logic [NH-1:0] hart_reset;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] rd_val;
    logic          rd_err;

    always #4 clk = ~clk;

    dbg_run_ctrl i_dbg_run_ctrl (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .req_valid_i    (req_valid),
        .req_write_i    (req_write),
        .req_addr_i     (req_addr),
        .req_wdata_i    (req_wdata),
        .rsp_valid_o    (rsp_valid),
        .rsp_err_o      (rsp_err),
        .rsp_rdata_o    (rsp_rdata),
        .hart_halted_i  (halted_in),
        .hart_resuming_i(resuming_in),
        .halt_req_o     (halt_req),
        .resume_req_o   (resume_req),
        .hart_reset_o   (hart_reset)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_val = rsp_rdata;
        rd_err = rsp_err;
        req_valid = 1'b0;
    endtask

    task automatic pulse(input logic [NH-1:0] h, input logic [NH-1:0] r);
        @(negedge clk);
        halted_in = h; resuming_in = r;
        @(posedge clk);
        @(negedge clk);
        halted_in = '0; resuming_in = '0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 halt", 32'(halt_req), 32'h0);
        check("R1 resume", 32'(resume_req), 32'h0);
        check("R1 reset", 32'(hart_reset), 32'h0);
        rd(A_CTRL);
        check("R1 ctrl", rd_val, 32'h0);
        rd(A_STAT);
        check("R8 status after reset", rd_val, 32'h2C0C);

        // R4 R7 R2 vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTRL, V_CTRL[i]);
            check("R4 table halt_req", 32'(halt_req), 32'(V_HALT[i]));
            rd(A_STAT);
            check("R7 table status", rd_val, V_STAT[i]);
        end

        // R6 halted notification
        pulse(4'b0010, 4'b0000);
        wr(A_CTRL, 32'h101);
        rd(A_STAT);
        check("R6 halted status", rd_val, 32'h2C03);

        // R5 resume handshake
        wr(A_CTRL, 32'h109);
        check("R5 resume flag", 32'(resume_req), 32'h2);
        rd(A_STAT);
        check("R5 ack cleared", rd_val, 32'h2C03);
        pulse(4'b0000, 4'b0010);
        check("R5 flag dropped", 32'(resume_req), 32'h0);
        rd(A_STAT);
        check("R5 running with ack", rd_val, 32'h2F0C);
        wr(A_CTRL, 32'h509);
        check("R5 nonexistent resume", 32'(resume_req), 32'h0);

        // R4 level halt
        wr(A_CTRL, 32'h111);
        rd(A_STAT);
        rd(A_STAT);
        check("R4 halt held", 32'(halt_req), 32'h2);
        wr(A_CTRL, 32'h101);
        check("R4 halt released", 32'(halt_req), 32'h0);

        // R2 R3 capture and activation clear
        wr(A_CTRL, 32'h209);
        check("R3 flag before", 32'(resume_req), 32'h4);
        wr(A_CTRL, 32'h000);
        check("R2 flag kept when inactive", 32'(resume_req), 32'h4);
        rd(A_CTRL);
        check("R2 fields kept", rd_val, 32'h208);
        wr(A_CTRL, 32'h201);
        check("R3 flag cleared on activation", 32'(resume_req), 32'h0);
        wr(A_CTRL, 32'h101);
        rd(A_STAT);
        check("R3 ack cleared on activation", rd_val, 32'h2C0C);

        // R9 resets
        wr(A_CTRL, 32'h003);
        check("R9 system reset", 32'(hart_reset), 32'hF);
        wr(A_CTRL, 32'h305);
        check("R9 hart reset", 32'(hart_reset), 32'h8);
        wr(A_CTRL, 32'h505);
        check("R9 nonexistent hart reset", 32'(hart_reset), 32'h0);
        wr(A_CTRL, 32'h001);
        check("R9 released", 32'(hart_reset), 32'h0);

        // R10 unmapped access
        rd(A_BAD);
        check("R10 unmapped data", rd_val, 32'h0);
        check("R10 unmapped err", 32'(rd_err), 32'h1);
        @(negedge clk);
        check("R10 err one cycle", 32'({rsp_valid, rsp_err}), 32'h0);
        wr(A_BAD, 32'hFFFF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_CTRL);
        check("R10 stray writes ignored", rd_val, 32'h001);
        check("R10 mapped read no err", 32'(rd_err), 32'h0);

        // R11 coincident halted and resuming
        wr(A_CTRL, 32'h009);
        check("R11 flag set", 32'(resume_req), 32'h1);
        pulse(4'b0001, 4'b0001);
        check("R11 flag dropped", 32'(resume_req), 32'h0);
        rd(A_STAT);
        check("R11 halted with ack", rd_val, 32'h2F03);

        finish_run();
    end

endmodule